// File: doc/BRIEF.md
# Region Cache Attribute Register Bank

This block keeps two attribute flags, cacheable and prefetchable, for every one of 256 equal slices of a 32-bit address space. Each slice spans 16 MiB, and the slice number is the top byte of the address.

Software sets the flags through a simple register port. A request is one cycle with valid, write, a byte offset and data. Read data returns on the cycle after the request. A lookup port takes any address and answers combinationally with the two flags of the slice that holds it. A cache controller uses this answer to decide how to treat a miss.

The lowest sixteen slices cover memories inside the core, and their attributes are fixed. Writes to those entries are dropped, and the entries always read as zero. Only two bits of each 32-bit register are implemented:

- bit 0 is the cache enable;
- bit 3 is the prefetch enable.

Every other bit reads as zero. Writing 0x0000_0009 turns both flags on for a slice, and writing 0x0000_0000 turns both off.

The register port is managed by a two-state machine:

- `ST_IDLE`: no read data is being returned. The transition to `ST_RESP` happens when a read request is accepted. The machine stays in `ST_IDLE` on a write or on no request.
- `ST_RESP`: the read data of the previous cycle's request is presented. The machine stays in `ST_RESP` on a back-to-back read. Any other cycle returns it to `ST_IDLE`.

Top module: `rcab_top`

## Requirements
- R1: After reset, every slice reports cache=0 and prefetch=0 on the lookup port, and every register reads 0.
- R2: The lookup port selects slice `lookup_addr[31:24]` and returns bit 0 of that slice's register as `lookup_cache` and bit 3 as `lookup_prefetch`. The result is combinational.
- R3: Register i sits at byte offset i*4 on the 10-bit `cfg_offset`. Offset bits [1:0] are ignored, so offset 0x3FF addresses register 255.
- R4: A write keeps only `cfg_wdata` bits 0 and 3. A read returns the stored value with every bit other than 0 and 3 at zero.
- R5: Registers 0 to 15 are read-only. Writes to them change nothing, they read 0, and lookups in slices 0 to 15 return both flags low.
- R6: A write accepted at a clock edge is seen on the lookup port from that edge onward. A lookup of the same slice in the write's own request cycle still shows the old flags.
- R7: A read request returns `cfg_rvalid`=1 with its data on the next cycle. Back-to-back reads give back-to-back responses. `cfg_rdata` is 0 whenever `cfg_rvalid` is 0.
- R8: A write request never raises `cfg_rvalid` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Register request present this cycle |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_offset | input | 10 | Byte offset of the register in the bank |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid (one cycle after a read) |
| cfg_rdata | output | 32 | Read data, zero when not valid |
| lookup_addr | input | 32 | Address to classify |
| lookup_cache | output | 1 | Slice of `lookup_addr` is cacheable |
| lookup_prefetch | output | 1 | Slice of `lookup_addr` is prefetchable |

## Verification
A write and a lookup can land on the same slice in the same cycle. The lookup must then show the old flags in the request cycle and the new flags from the next cycle on.

The bench provokes this collision on purpose, including a disable that follows an enable. It also biases its random phase so that the lookup address often hits the slice being written.

A behavioural model updates its flag arrays only at the clock edge. It is compared with the lookup outputs and the read port on every cycle, so a design that forwards write data early, or one that lags a cycle, is caught.

// File: rtl/rcab_pkg.sv
package rcab_pkg;
    localparam int CACHE_POS = 0;
    localparam int PREF_POS  = 3;

    typedef struct packed {
        logic pref;
        logic cache;
    } attr_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_t;
endpackage

// File: rtl/rcab_store.sv
module rcab_store
    import rcab_pkg::*;
#(
    parameter int NREG   = 256,
    parameter int RO_CNT = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  attr_t            wr_bits,
    output logic [NREG-1:0]  cache_map,
    output logic [NREG-1:0]  pref_map
);
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g < RO_CNT) begin : g_fixed
            assign cache_map[g] = 1'b0;
            assign pref_map[g]  = 1'b0;
        end else begin : g_flop
            logic sel;
            assign sel = wr_en && (wr_idx == IDX_W'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cache_map[g] <= 1'b0;
                    pref_map[g]  <= 1'b0;
                end else if (sel) begin
                    cache_map[g] <= wr_bits.cache;
                    pref_map[g]  <= wr_bits.pref;
                end
            end
        end
    end

    // R5: a write aimed at a fixed slot must leave the map's fixed part low
    p_fixed_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < IDX_W'(RO_CNT)) |=> (cache_map[RO_CNT-1:0] == '0 && pref_map[RO_CNT-1:0] == '0));
endmodule

// File: rtl/rcab_cfg_port.sv
module rcab_cfg_port
    import rcab_pkg::*;
#(
    parameter int NREG   = 256,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int OFF_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NREG-1:0]   cache_map,
    input  logic [NREG-1:0]   pref_map,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output attr_t             wr_bits,
    output logic              cfg_rvalid,
    output logic [DATA_W-1:0] cfg_rdata
);
    port_state_t state_q, state_d;
    logic [DATA_W-1:0] rd_q;
    logic [IDX_W-1:0]  req_idx;
    logic              rd_req;
    logic [1:0]        unused_low;

    assign unused_low = cfg_offset[1:0];
    assign req_idx    = cfg_offset[OFF_W-1:2];
    assign rd_req     = cfg_valid && !cfg_write;

    assign wr_en         = cfg_valid && cfg_write;
    assign wr_idx        = req_idx;
    assign wr_bits.cache = cfg_wdata[CACHE_POS];
    assign wr_bits.pref  = cfg_wdata[PREF_POS];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_req) begin
            rd_q <= '0;
            rd_q[CACHE_POS] <= cache_map[req_idx];
            rd_q[PREF_POS]  <= pref_map[req_idx];
        end
    end

    always_comb begin
        cfg_rvalid = 1'b0;
        cfg_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                cfg_rvalid = 1'b1;
                cfg_rdata  = rd_q;
            end
            default: ;
        endcase
    end

    p_read_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> cfg_rvalid);
    p_write_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !cfg_rvalid);
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rvalid |-> cfg_rdata == '0);
endmodule

// File: rtl/rcab_lookup.sv
module rcab_lookup #(
    parameter int NREG   = 256,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NREG-1:0]   cache_map,
    input  logic [NREG-1:0]   pref_map,
    output logic              hit_cache,
    output logic              hit_pref
);
    logic [IDX_W-1:0]        slot;
    logic [ADDR_W-IDX_W-1:0] unused_low;

    assign slot       = addr[ADDR_W-1 -: IDX_W];
    assign unused_low = addr[ADDR_W-IDX_W-1:0];
    assign hit_cache  = cache_map[slot];
    assign hit_pref   = pref_map[slot];
endmodule

// File: rtl/rcab_top.sv
module rcab_top
    import rcab_pkg::*;
#(
    parameter int NREG   = 256,
    parameter int RO_CNT = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG),
    localparam int OFF_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_rvalid,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] lookup_addr,
    output logic              lookup_cache,
    output logic              lookup_prefetch
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    attr_t             wr_bits;
    logic [NREG-1:0]   cache_map;
    logic [NREG-1:0]   pref_map;

    rcab_cfg_port #(.NREG(NREG), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_offset(cfg_offset), .cfg_wdata(cfg_wdata),
        .cache_map(cache_map), .pref_map(pref_map),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bits(wr_bits),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
    );

    rcab_store #(.NREG(NREG), .RO_CNT(RO_CNT)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bits(wr_bits),
        .cache_map(cache_map), .pref_map(pref_map)
    );

    rcab_lookup #(.NREG(NREG), .ADDR_W(ADDR_W)) u_lookup (
        .addr(lookup_addr), .cache_map(cache_map), .pref_map(pref_map),
        .hit_cache(lookup_cache), .hit_pref(lookup_prefetch)
    );

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] off_idx;
    assign lk_idx  = lookup_addr[ADDR_W-1 -: IDX_W];
    assign off_idx = cfg_offset[OFF_W-1:2];

    p_ro_lookup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_idx < IDX_W'(RO_CNT)) |-> (!lookup_cache && !lookup_prefetch));

    p_write_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_write && off_idx >= IDX_W'(RO_CNT)) |=>
        ((lk_idx != $past(off_idx)) ||
         (lookup_cache == $past(cfg_wdata[CACHE_POS]) &&
          lookup_prefetch == $past(cfg_wdata[PREF_POS]))));

    p_rdata_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~((DATA_W'(1) << CACHE_POS) | (DATA_W'(1) << PREF_POS))) == '0);
endmodule

// File: tb/tb_rcab_top.sv
module tb_rcab_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [9:0]  cfg_offset = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic [31:0] lookup_addr = '0;
    logic        lookup_cache;
    logic        lookup_prefetch;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit ref_c [256];
    bit ref_p [256];
    bit exp_rv;
    logic [31:0] exp_rd;

    always #10 clk = ~clk;

    rcab_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_offset(cfg_offset), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .lookup_addr(lookup_addr),
        .lookup_cache(lookup_cache), .lookup_prefetch(lookup_prefetch)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural model, updated at the edge like a register file
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin ref_c[i] <= 1'b0; ref_p[i] <= 1'b0; end
            exp_rv <= 1'b0;
            exp_rd <= '0;
        end else begin
            exp_rv <= cfg_valid && !cfg_write;
            if (cfg_valid && !cfg_write)
                exp_rd <= {28'd0, ref_p[cfg_offset[9:2]], 2'b00, ref_c[cfg_offset[9:2]]};
            if (cfg_valid && cfg_write && cfg_offset[9:2] >= 8'd16) begin
                ref_c[cfg_offset[9:2]] <= cfg_wdata[0];
                ref_p[cfg_offset[9:2]] <= cfg_wdata[3];
            end
        end
    end

    // every-cycle comparison, 5 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && !done) begin
                chk(lookup_cache == ref_c[lookup_addr[31:24]] && lookup_prefetch == ref_p[lookup_addr[31:24]],
                    "R2 R6 lookup flags", {30'd0, lookup_prefetch, lookup_cache},
                    {30'd0, ref_p[lookup_addr[31:24]], ref_c[lookup_addr[31:24]]});
                chk(cfg_rvalid == exp_rv, "R7 R8 rvalid", {31'd0, cfg_rvalid}, {31'd0, exp_rv});
                if (exp_rv) chk(cfg_rdata == exp_rd, "R4 read data", cfg_rdata, exp_rd);
                else        chk(cfg_rdata == 32'd0, "R7 idle rdata", cfg_rdata, 32'd0);
            end
        end
    end

    task automatic do_write(input logic [9:0] off, input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_offset = off; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_offset = off;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(cfg_rvalid == 1'b1 && cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic look(input logic [31:0] a, input bit c, input bit p, input string tag);
        @(negedge clk);
        lookup_addr = a;
        #1;
        chk(lookup_cache == c && lookup_prefetch == p, tag,
            {30'd0, lookup_prefetch, lookup_cache}, {30'd0, p, c});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything clear after reset
        for (int i = 0; i < 256; i++) look({i[7:0], 24'h00_1234}, 1'b0, 1'b0, "R1 reset lookup");
        do_read(10'h380, 32'd0, "R1 reset read");

        // R6: write to slice E0 while looking it up in the same cycle
        @(negedge clk);
        lookup_addr = 32'hE012_3456;
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_offset = 10'h380; cfg_wdata = 32'h0000_0009;
        #1;
        chk(lookup_cache == 1'b0 && lookup_prefetch == 1'b0, "R6 same-cycle old value",
            {30'd0, lookup_prefetch, lookup_cache}, 32'd0);
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
        #1;
        chk(lookup_cache == 1'b1 && lookup_prefetch == 1'b1, "R6 next-cycle new value",
            {30'd0, lookup_prefetch, lookup_cache}, 32'd3);
        do_read(10'h380, 32'h0000_0009, "R3 R4 read E0");

        // R6: disable in the same cycle as the lookup
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_offset = 10'h380; cfg_wdata = 32'h0;
        #1;
        chk(lookup_cache == 1'b1, "R6 same-cycle before clear", {31'd0, lookup_cache}, 32'd1);
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
        #1;
        chk(lookup_cache == 1'b0 && lookup_prefetch == 1'b0, "R6 after clear",
            {30'd0, lookup_prefetch, lookup_cache}, 32'd0);

        // R5: read-only slices, edge at 15 and 16
        do_write(10'h014, 32'hFFFF_FFFF);
        look(32'h0500_0000, 1'b0, 1'b0, "R5 ro lookup 5");
        do_read(10'h014, 32'd0, "R5 ro read 5");
        do_write(10'h03C, 32'h0000_0009);
        do_read(10'h03C, 32'd0, "R5 ro read 15");
        look(32'h0FFF_FFFF, 1'b0, 1'b0, "R5 ro lookup 15");
        do_write(10'h040, 32'h0000_0009);
        do_read(10'h040, 32'h0000_0009, "R5 first writable 16");
        look(32'h1000_0000, 1'b1, 1'b1, "R2 lookup 16");

        // R4: masking of unimplemented bits
        do_write(10'h080, 32'hFFFF_FFF6);
        do_read(10'h080, 32'd0, "R4 no bits 0/3");
        do_write(10'h084, 32'hFFFF_FFF7);
        do_read(10'h084, 32'h0000_0001, "R4 cache only");
        look(32'h2100_0000, 1'b1, 1'b0, "R2 cache only lookup");
        do_write(10'h088, 32'h0000_0008);
        do_read(10'h088, 32'h0000_0008, "R4 prefetch only");
        look(32'h22AB_CDEF, 1'b0, 1'b1, "R2 prefetch only lookup");

        // R3: low offset bits ignored
        do_write(10'h3FF, 32'h0000_0009);
        do_read(10'h3FC, 32'h0000_0009, "R3 offset 3FF -> reg 255");
        look(32'hFFFF_FFFF, 1'b1, 1'b1, "R3 lookup 255");
        do_read(10'h07D, 32'd0, "R3 offset 7D -> reg 31");

        // R7: back-to-back reads
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_offset = 10'h040;
        @(negedge clk);
        chk(cfg_rvalid && cfg_rdata == 32'h9, "R7 b2b first", cfg_rdata, 32'h9);
        cfg_offset = 10'h084;
        @(negedge clk);
        chk(cfg_rvalid && cfg_rdata == 32'h1, "R7 b2b second", cfg_rdata, 32'h1);
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_offset = 10'h090; cfg_wdata = 32'h8;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
        chk(!cfg_rvalid && cfg_rdata == 32'd0, "R8 write after read", cfg_rdata, 32'd0);

        // mixed random traffic, lookups biased to the slice being touched
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            cfg_valid  = ($urandom_range(0, 3) != 0);
            cfg_write  = $urandom_range(0, 1);
            cfg_offset = 10'($urandom);
            cfg_wdata  = $urandom;
            if ($urandom_range(0, 1) == 1) lookup_addr = {cfg_offset[9:2], 24'($urandom)};
            else                           lookup_addr = $urandom;
        end
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule